// File: doc/BRIEF.md
# I2C Slave Byte Shifter with Start-Triggered Restart

This block is the bit engine of a slave-side I2C peripheral. It watches an externally supplied serial clock, shifts one byte out on the data line and one byte in per frame, and counts nine clocks per frame: eight data bits followed by one acknowledge bit. Data goes most significant bit first. The output bit changes on a falling SCL edge, and the input bit is sampled on a rising SCL edge.

A separate detector supplies a one-cycle START pulse. If the restart feature is enabled and the external clock is selected, that pulse reinitializes the engine. The transmit shifter reloads from the transmit buffer, the receive shifter and the bit counter clear, and the clock-wait bit is set. The wait bit makes the block hold SCL low from the falling edge of the ninth clock. The hold ends when software clears the bit. The transmit-buffer-empty flag is not touched by the restart.

Outgoing bytes enter through a valid/ready stream. `tx_ready_o` is the buffer-empty flag, and a byte is taken on any cycle where valid and ready are both high. A producer that keeps valid high while ready is low simply waits. Received bytes leave through a valid/ready stream. `rx_valid_o` stays high until a cycle with `rx_ready_i` high. A consumer that never accepts does not stall the bus: the next completed byte replaces the held one.

Top module: `i2c_slave_shifter`

## Requirements
- R1: After reset, `sda_o` is 1, `scl_hold_o` is 0, `tx_ready_o` is 1, `rx_valid_o` is 0 and `wait_q_o` is 0.
- R2: Transmit bits leave MSB first. Each bit after the first is driven on a falling SCL edge.
- R3: A receive bit is sampled on each of the first eight rising SCL edges of a frame, MSB first. The ninth rising edge copies the byte to `rx_data_o`, sets `rx_valid_o`, and pulses `rx_done_o` for one cycle.
- R4: On the falling edge after the eighth rising edge, `sda_o` takes the level of `ack_level_i` for the acknowledge slot.
- R5: A START with `init_en_i`=1 and `clk_ext_i`=1 does three things: it loads the transmit buffer into the transmit shifter, clears the receive shifter, and restarts the bit count at zero. `tx_ready_o` keeps its value.
- R6: At such a START, `sda_o` keeps its current level. It changes first on the next falling SCL edge, where it takes the MSB of the reloaded byte.
- R7: Such a START sets `wait_q_o`. While `wait_q_o` is 1, the ninth falling edge raises `scl_hold_o` and defers the next reload, and `sda_o` keeps its acknowledge level. Clearing the bit with `wait_we_i` drops `scl_hold_o` and performs the deferred reload.
- R8: A START with `init_en_i`=0, or with `clk_ext_i`=0, changes nothing. The frame in progress completes at its normal ninth rising edge with all eight bits, and `wait_q_o` and `sda_o` stay as they were.
- R9: A byte is taken into the buffer when `tx_valid_i` and `tx_ready_o` are both high, which drops `tx_ready_o`. A normal reload moves the buffer into the shifter, raises `tx_ready_o`, and drives the new MSB. A reload with an empty buffer sends all ones.
- R10: `rx_valid_o` stays high until a cycle with `rx_ready_i` high. An unaccepted byte is overwritten by the next completed byte.
- R11: With `wait_q_o` at 0, the ninth falling edge does not hold SCL. It reloads at once, so the next byte's MSB is on `sda_o` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data from the bus |
| start_det_i | input | 1 | One-cycle START-detected pulse |
| clk_ext_i | input | 1 | 1 when the incoming SCL is the selected transfer clock |
| init_en_i | input | 1 | Enables restart on START |
| wait_we_i | input | 1 | Write strobe for the clock-wait bit |
| wait_wd_i | input | 1 | Value written to the clock-wait bit |
| wait_q_o | output | 1 | Current clock-wait bit |
| ack_level_i | input | 1 | Level driven during the acknowledge slot |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | DATA_W | Transmit byte |
| tx_ready_o | output | 1 | Transmit buffer empty / byte accepted |
| rx_valid_o | output | 1 | Received byte held |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| rx_data_o | output | DATA_W | Received byte |
| rx_done_o | output | 1 | One-cycle receive-complete strobe |
| sda_o | output | 1 | Data level for the pad driver |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
The hardest case to reach is a restart that arrives part-way through a byte. At that moment the transmit shifter, the receive shifter, the bit count and the output level all carry state from the abandoned frame. The bench clocks a few bits of a frame, raises SCL and fires START. It then expects the held `sda_o` level, the unchanged empty flag, and a complete correct byte in both directions. A correct byte is only possible if every piece of state restarted together. A full sweep of all 256 transmit values does the same from a frame boundary. Each step of that sweep walks the clock-wait hold and its deferred reload.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // Frame events decoded from the bit count and the SCL edges.
  typedef struct packed {
    logic sample_rise; // rising edge of a data bit
    logic ack_rise;    // rising edge of the acknowledge bit (9th)
    logic first_fall;  // falling edge with count at zero
    logic shift_fall;  // falling edge inside the data bits
    logic ack_fall;    // falling edge that opens the acknowledge slot
    logic end_fall;    // falling edge of the 9th clock
  } bit_evt_t;
endpackage

// File: rtl/i2cs_scl_edge.sv
module i2cs_scl_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] pipe_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= 1'b1;
        else        pipe_q[g] <= scl_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= 1'b1;
        else        pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pipe_q[SYNC_STAGES-1];
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~pipe_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/i2cs_frame_counter.sv
module i2cs_frame_counter
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rise_i,
  input  logic     fall_i,
  input  logic     restart_i,
  output bit_evt_t evt_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    evt_o.sample_rise = rise_i & (cnt_q < ACK_CNT);
    evt_o.ack_rise    = rise_i & (cnt_q == ACK_CNT);
    evt_o.first_fall  = fall_i & (cnt_q == '0);
    evt_o.shift_fall  = fall_i & (cnt_q != '0) & (cnt_q < ACK_CNT);
    evt_o.ack_fall    = fall_i & (cnt_q == ACK_CNT);
    evt_o.end_fall    = fall_i & (cnt_q == END_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (restart_i)                 cnt_q <= '0;
    else if (rise_i && cnt_q <= ACK_CNT) cnt_q <= cnt_q + 1'b1;
    else if (evt_o.end_fall)            cnt_q <= '0;
  end
endmodule

// File: rtl/i2cs_tx_path.sv
module i2cs_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              restart_i,
  input  logic              reload_i,
  input  logic              first_fall_i,
  input  logic              shift_fall_i,
  input  logic              ack_fall_i,
  input  logic              ack_level_i,
  output logic              sda_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] buf_q, sr_q, src;
  logic              empty_q, first_q, sda_q;
  logic              accept;

  assign accept     = tx_valid_i & empty_q;
  assign src        = empty_q ? {DATA_W{1'b1}} : buf_q;
  assign tx_ready_o = empty_q;
  assign sda_o      = sda_q;

  // Buffer and its empty flag; a restart leaves both alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '1;
      empty_q <= 1'b1;
    end else if (accept) begin
      buf_q   <= tx_data_i;
      empty_q <= 1'b0;
    end else if (reload_i && !empty_q) begin
      empty_q <= 1'b1;
    end
  end

  // Shifter and line level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '1;
      first_q <= 1'b0;
      sda_q   <= 1'b1;
    end else if (restart_i) begin
      sr_q    <= buf_q;
      first_q <= 1'b1;
    end else if (reload_i) begin
      sda_q   <= src[MSB];
      sr_q    <= {src[MSB-1:0], 1'b1};
      first_q <= 1'b0;
    end else if ((first_fall_i && first_q) || shift_fall_i) begin
      sda_q   <= sr_q[MSB];
      sr_q    <= {sr_q[MSB-1:0], 1'b1};
      first_q <= 1'b0;
    end else if (ack_fall_i) begin
      sda_q   <= ack_level_i;
    end
  end
endmodule

// File: rtl/i2cs_rx_path.sv
module i2cs_rx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              restart_i,
  input  logic              sample_i,
  input  logic              commit_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o
);
  logic [DATA_W-1:0] sr_q, data_q;
  logic              valid_q, done_q;

  assign rx_valid_o = valid_q;
  assign rx_data_o  = data_q;
  assign rx_done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (restart_i)  sr_q <= '0;
    else if (sample_i)   sr_q <= {sr_q[DATA_W-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit_i;
      if (commit_i) begin
        data_q  <= sr_q;
        valid_q <= 1'b1;
      end else if (valid_q && rx_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_slave_shifter.sv
module i2c_slave_shifter
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_det_i,
  input  logic              clk_ext_i,
  input  logic              init_en_i,
  input  logic              wait_we_i,
  input  logic              wait_wd_i,
  output logic              wait_q_o,
  input  logic              ack_level_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              sda_o,
  output logic              scl_hold_o
);
  logic     scl_rise, scl_fall;
  bit_evt_t evt;
  logic     restart, release_hold, reload;
  logic     wait_q, hold_q, pend_q;

  // Restart only when enabled and the bus clock is the transfer clock.
  assign restart      = start_det_i & init_en_i & clk_ext_i;
  assign release_hold = hold_q & ~wait_q;
  assign reload       = ~restart &
                        ((evt.end_fall & ~wait_q) | (release_hold & pend_q));

  assign wait_q_o   = wait_q;
  assign scl_hold_o = hold_q;

  i2cs_scl_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  i2cs_frame_counter #(.DATA_W(DATA_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .restart_i (restart),
    .evt_o     (evt)
  );

  i2cs_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid_i   (tx_valid_i),
    .tx_data_i    (tx_data_i),
    .tx_ready_o   (tx_ready_o),
    .restart_i    (restart),
    .reload_i     (reload),
    .first_fall_i (evt.first_fall),
    .shift_fall_i (evt.shift_fall),
    .ack_fall_i   (evt.ack_fall),
    .ack_level_i  (ack_level_i),
    .sda_o        (sda_o)
  );

  i2cs_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_i      (sda_i),
    .restart_i  (restart),
    .sample_i   (evt.sample_rise),
    .commit_i   (evt.ack_rise),
    .rx_ready_i (rx_ready_i),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .rx_done_o  (rx_done_o)
  );

  // Clock-wait bit, SCL hold request and deferred reload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      hold_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (restart)        wait_q <= 1'b1;
      else if (wait_we_i) wait_q <= wait_wd_i;

      if (release_hold)                hold_q <= 1'b0;
      else if (evt.end_fall && wait_q) hold_q <= 1'b1;

      if (restart || release_hold)     pend_q <= 1'b0;
      else if (evt.end_fall && wait_q) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_slave_shifter_chk.sv
module i2c_slave_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic start_det_i,
  input logic init_en_i,
  input logic clk_ext_i,
  input logic wait_we_i,
  input logic wait_q_o,
  input logic sda_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic scl_hold_o,
  input logic rx_done_o,
  input logic rx_valid_o,
  input logic rx_ready_i
);
  logic go;
  assign go = start_det_i & init_en_i & clk_ext_i;

  p_start_keeps_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go && !tx_valid_i |=> $stable(tx_ready_o));

  p_start_holds_sda_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> $stable(sda_o));

  p_start_sets_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> wait_q_o);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o && !wait_q_o |=> !scl_hold_o);

  p_ignored_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det_i && !(init_en_i && clk_ext_i) && !wait_we_i |=> $stable(wait_q_o));

  p_done_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_o |-> rx_valid_o);

  p_valid_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);

  p_hold_needs_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold_o) |-> $past(wait_q_o));
endmodule

bind i2c_slave_shifter i2c_slave_shifter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_det_i (start_det_i),
  .init_en_i   (init_en_i),
  .clk_ext_i   (clk_ext_i),
  .wait_we_i   (wait_we_i),
  .wait_q_o    (wait_q_o),
  .sda_o       (sda_o),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .scl_hold_o  (scl_hold_o),
  .rx_done_o   (rx_done_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ready_i  (rx_ready_i)
);

// File: tb/i2c_slave_shifter_test.sv
`timescale 1ns/1ps
module i2c_slave_shifter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl = 1'b1, sda_in = 1'b1, start_det = 1'b0, clk_ext = 1'b1, init_en = 1'b1;
  logic wait_we = 1'b0, wait_wd = 1'b0, ack_level = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic wait_q, tx_ready, rx_valid, rx_done, sda_o, scl_hold;
  logic [7:0] rx_data;

  int checks = 0, failures = 0, done_cnt = 0, exp_done = 0, cycles = 0;

  i2c_slave_shifter uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_in), .start_det_i(start_det),
    .clk_ext_i(clk_ext), .init_en_i(init_en), .wait_we_i(wait_we), .wait_wd_i(wait_wd),
    .wait_q_o(wait_q), .ack_level_i(ack_level), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .rx_done_o(rx_done), .sda_o(sda_o), .scl_hold_o(scl_hold)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rx_done) done_cnt <= done_cnt + 1;
    if (cycles == 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog all-reqs actual=%0d expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_set(input logic v);
    @(negedge clk) scl = v;
    step(8);
  endtask

  task automatic pulse_start(input logic ie, input logic ce);
    @(negedge clk);
    start_det = 1'b1; init_en = ie; clk_ext = ce;
    @(negedge clk);
    start_det = 1'b0; init_en = 1'b1; clk_ext = 1'b1;
    step(2);
  endtask

  task automatic set_wait(input logic v);
    @(negedge clk); wait_we = 1'b1; wait_wd = v;
    @(negedge clk); wait_we = 1'b0;
    step(2);
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
    step(1);
  endtask

  task automatic pop_rx;
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    step(1);
  endtask

  // One frame; inject: 0 none, 1 START with init_en=0, 2 START with clk_ext=0.
  task automatic frame(input logic [7:0] exp_tx, input logic [7:0] rxb,
                       input bit from_start, input int inject);
    logic s0, w0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0 || from_start) scl_set(1'b0);
      chk(sda_o === exp_tx[7-i], "R2 tx bit", sda_o, exp_tx[7-i]);
      sda_in = rxb[7-i];
      scl_set(1'b1);
      if (i == 3 && inject != 0) begin
        s0 = sda_o; w0 = wait_q;
        pulse_start(inject == 1 ? 1'b0 : 1'b1, inject == 1 ? 1'b1 : 1'b0);
        chk(wait_q === w0, "R8 wait bit", wait_q, w0);
        chk(sda_o === s0, "R8 sda level", sda_o, s0);
      end
    end
    scl_set(1'b0);
    chk(sda_o === ack_level, "R4 ack slot", sda_o, ack_level);
    scl_set(1'b1);
    exp_done++;
    chk(rx_valid === 1'b1 && rx_data === rxb, "R3 rx byte", rx_data, rxb);
    chk(done_cnt == exp_done, "R3 strobe count", done_cnt, exp_done);
    scl_set(1'b0);
  endtask

  initial begin
    logic prev;
    logic [7:0] rxv;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(sda_o === 1'b1, "R1 sda", sda_o, 1);
    chk(scl_hold === 1'b0, "R1 hold", scl_hold, 0);
    chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(wait_q === 1'b0, "R1 wait", wait_q, 0);

    // Sweep every transmit byte, each started by an enabled START.
    for (int v = 0; v < 256; v++) begin
      if (v > 0) scl_set(1'b1);
      ack_level = v[0];
      prev = (v == 0) ? 1'b1 : 1'(((v - 1) >> 7) & 1);
      push_tx(8'(v));
      chk(tx_ready === 1'b0, "R9 accept", tx_ready, 0);
      pulse_start(1'b1, 1'b1);
      chk(sda_o === prev, "R6 sda held at start", sda_o, prev);
      chk(tx_ready === 1'b0, "R5 flag untouched", tx_ready, 0);
      chk(wait_q === 1'b1, "R7 wait set", wait_q, 1);
      rxv = 8'(v * 37 + 11);
      frame(8'(v), rxv, 1'b1, 0);
      chk(scl_hold === 1'b1, "R7 hold at 9th fall", scl_hold, 1);
      chk(sda_o === ack_level, "R7 reload deferred", sda_o, ack_level);
      pop_rx;
      chk(rx_valid === 1'b0, "R10 accepted", rx_valid, 0);
      set_wait(1'b0);
      step(2);
      chk(scl_hold === 1'b0, "R7 release", scl_hold, 0);
      chk(tx_ready === 1'b1, "R9 reload empties", tx_ready, 1);
      chk(sda_o === v[7], "R9 reload msb", sda_o, v[7]);
    end

    // Wait bit clear: no hold, immediate reload (buffer reloads 0xFF remainder).
    ack_level = 1'b0;
    push_tx(8'h3C);
    frame(8'hFF, 8'h5A, 1'b0, 0);
    chk(scl_hold === 1'b0, "R11 no hold", scl_hold, 0);
    chk(sda_o === 1'b0, "R11 next msb", sda_o, 0);
    chk(tx_ready === 1'b1, "R9 reload empties", tx_ready, 1);
    frame(8'h3C, 8'hC3, 1'b0, 0);
    chk(rx_valid === 1'b1 && rx_data === 8'hC3, "R10 overwrite", rx_data, 8'hC3);
    chk(sda_o === 1'b1, "R9 empty sends ones", sda_o, 1);

    // Ignored STARTs mid-byte.
    pop_rx;
    frame(8'hFF, 8'h69, 1'b0, 1);
    pop_rx;
    frame(8'hFF, 8'h0F, 1'b0, 2);
    chk(wait_q === 1'b0, "R8 wait unchanged", wait_q, 0);

    // Restart part-way through a byte.
    push_tx(8'h96);
    pop_rx;
    scl_set(1'b1); scl_set(1'b0); scl_set(1'b1); scl_set(1'b0); scl_set(1'b1);
    prev = sda_o;
    pulse_start(1'b1, 1'b1);
    chk(sda_o === prev, "R6 sda held mid-byte", sda_o, prev);
    chk(tx_ready === 1'b0, "R5 flag untouched", tx_ready, 0);
    frame(8'h96, 8'hE1, 1'b1, 0);
    chk(scl_hold === 1'b1, "R7 hold after restart", scl_hold, 1);
    set_wait(1'b0);
    step(2);
    chk(scl_hold === 1'b0 && sda_o === 1'b1, "R7 release reload", sda_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule